// File: doc/BRIEF.md
# Full-Period de Bruijn Sequence Counter

This block steps an n-bit shift register through every one of its 2^n states, including the all-zero state, before the sequence repeats. Its basis is a maximal-length XOR-feedback shift register. On its own, that register cycles through 2^n-1 states and can never leave the all-zero state once it is there. A correction term is added to the feedback. This term is the NOR of every stage except the last one. It detours the sequence through the all-zero state and back out again, so the period becomes exactly 2^n.

All stages move together on one clock edge. The feedback bit enters the first stage, and every other stage takes the value of the stage below it. The last stage is also driven out as a serial bit stream. A synchronous reset clears the register to all zeros, which is a valid state here. A load strobe writes any seed value into the register. An advance enable lets the register step. When neither is active, the register holds its value. The width parameter selects one entry from a fixed table of maximal tap sets.

Top module: `debruijn_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves `state_q` equal to all zeros after that edge.
- R2: When `seed_load` is high at an edge, `state_q` takes `seed_val` after that edge, whatever the value of `adv_en`.
- R3: When `seed_load` and `adv_en` are both low at an edge, `state_q` keeps its value.
- R4: On an advance (`adv_en` high and `seed_load` low), bit k of the new state equals bit k-1 of the old state for k from 1 to N-1. New bit 0 equals the XOR of the tapped bits, XORed with the NOR of old bits N-2 down to 0.
- R5: Advancing from the all-zero state gives the state with only bit 0 set.
- R6: Advancing from the state with only bit N-1 set gives the all-zero state.
- R7: Starting from reset, 2^N consecutive advances visit 2^N distinct states. After exactly 2^N advances, the register is back at its starting state.
- R8: `ser_out` always equals `state_q[N-1]`.
- R9: The tap set depends on N. For N=4 it is bits {3,2}. For N=8 it is bits {7,5,4,3}, which are stages 8, 6, 5 and 4. For N=16 it is bits {15,13,12,10}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the all-zero state |
| seed_load | input | 1 | Writes `seed_val` into the register; takes precedence over advancing |
| seed_val | input | N | Seed value to load |
| adv_en | input | 1 | Steps the sequence by one state |
| state_q | output | N | Full parallel register state |
| ser_out | output | 1 | Serial output, equal to the last stage |

## Verification
A seed load and an advance request can occur in the same cycle. The bench raises `seed_load` and `adv_en` together, using seeds that differ from the stepped value. It then checks that the register holds the seed and not the next state of the sequence. A reference model runs beside the design and predicts every cycle: load wins over advance, advance wins over hold. One full period is walked from reset against a visited bitmap. Both splice points, into and out of the all-zero state, are also reached directly by loading their neighbouring states.

// File: rtl/dbj_pkg.sv
package dbj_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_ADV  = 2'd2
    } act_e;

    typedef struct packed {
        logic load;
        logic adv;
    } step_req_t;

    // Maximal tap sets as bit masks (bit index = stage number - 1).
    function automatic logic [15:0] tap_mask(input int width);
        case (width)
            4:       return 16'h000C;   // stages 4,3
            8:       return 16'h00B8;   // stages 8,6,5,4
            16:      return 16'hB400;   // stages 16,14,13,11
            default: return 16'h0000;
        endcase
    endfunction

    function automatic act_e pick_action(input step_req_t req);
        if (req.load)     return ACT_LOAD;
        else if (req.adv) return ACT_ADV;
        else              return ACT_HOLD;
    endfunction

endpackage

// File: rtl/dbj_step_ctrl.sv
module dbj_step_ctrl
    import dbj_pkg::*;
(
    input  logic seed_load,
    input  logic adv_en,
    output act_e act
);
    step_req_t req;

    always_comb begin
        req.load = seed_load;
        req.adv  = adv_en;
        act      = pick_action(req);
    end
endmodule

// File: rtl/dbj_feedback.sv
module dbj_feedback
    import dbj_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] cur,
    output logic         fb_bit
);
    localparam logic [N-1:0] TAPS = N'(tap_mask(N));
    localparam int           LOWW = N - 1;

    logic lin_bit;
    logic low_zero;

    // Linear part: parity of the tapped stages.
    assign lin_bit = ^(cur & TAPS);

    // Splice term: flat reduction so synthesis can build a balanced tree.
    generate
        if (LOWW >= 1) begin : g_nor
            assign low_zero = ~|cur[LOWW-1:0];
        end else begin : g_nor_one
            assign low_zero = 1'b1;
        end
    endgenerate

    assign fb_bit = lin_bit ^ low_zero;
endmodule

// File: rtl/dbj_shift_reg.sv
module dbj_shift_reg
    import dbj_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  act_e         act,
    input  logic [N-1:0] seed,
    input  logic         fb_bit,
    output logic [N-1:0] q
);
    logic [N-1:0] nxt;

    always_comb begin
        unique case (act)
            ACT_LOAD: nxt = seed;
            ACT_ADV:  nxt = {q[N-2:0], fb_bit};
            default:  nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/debruijn_gen.sv
module debruijn_gen
    import dbj_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seed_load,
    input  logic [N-1:0] seed_val,
    input  logic         adv_en,
    output logic [N-1:0] state_q,
    output logic         ser_out
);
    act_e act;
    logic fb_bit;

    dbj_step_ctrl u_ctrl (
        .seed_load (seed_load),
        .adv_en    (adv_en),
        .act       (act)
    );

    dbj_feedback #(.N(N)) u_fb (
        .cur    (state_q),
        .fb_bit (fb_bit)
    );

    dbj_shift_reg #(.N(N)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .seed   (seed_val),
        .fb_bit (fb_bit),
        .q      (state_q)
    );

    assign ser_out = state_q[N-1];
endmodule

// File: rtl/dbj_checker.sv
module dbj_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         seed_load,
    input logic [N-1:0] seed_val,
    input logic         adv_en,
    input logic [N-1:0] state_q,
    input logic         ser_out
);
    localparam logic [N-1:0] ZERO = '0;
    localparam logic [N-1:0] ONE  = N'(1);
    localparam logic [N-1:0] TOP  = ONE << (N - 1);

    logic armed = 1'b0;
    always_ff @(posedge clk) if (rst) armed <= 1'b1;

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!armed)
        rst |=> state_q == ZERO);

    assert_load_wins_R2: assert property (@(posedge clk) disable iff (rst || !armed)
        seed_load |=> state_q == $past(seed_val));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        (!seed_load && !adv_en) |=> $stable(state_q));

    assert_shift_R4: assert property (@(posedge clk) disable iff (rst || !armed)
        (adv_en && !seed_load) |=> state_q[N-1:1] == $past(state_q[N-2:0]));

    assert_leave_zero_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        (adv_en && !seed_load && state_q == ZERO) |=> state_q == ONE);

    assert_enter_zero_R6: assert property (@(posedge clk) disable iff (rst || !armed)
        (adv_en && !seed_load && state_q == TOP) |=> state_q == ZERO);

    assert_serial_R8: assert property (@(posedge clk) disable iff (rst || !armed)
        ser_out == state_q[N-1]);
endmodule

bind debruijn_gen dbj_checker #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .seed_load (seed_load),
    .seed_val  (seed_val),
    .adv_en    (adv_en),
    .state_q   (state_q),
    .ser_out   (ser_out)
);

// File: tb/tb_debruijn_gen.sv
module tb_debruijn_gen;
    localparam int  N      = 8;
    localparam int  PERIOD = 1 << N;
    localparam time CLK_T  = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         seed_load = 1'b0;
    logic [N-1:0] seed_val = '0;
    logic         adv_en = 1'b0;
    logic [N-1:0] state_q;
    logic         ser_out;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    int model;                      // reference state as an integer
    int stages[4] = '{8, 6, 5, 4};  // R9: 8-bit tap stages

    debruijn_gen #(.N(N)) dut (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_val(seed_val),
        .adv_en(adv_en), .state_q(state_q), .ser_out(ser_out)
    );

    always #(CLK_T/2) clk = ~clk;

    function automatic int model_next(input int s);
        int fb = 0;
        foreach (stages[i]) fb ^= (s >> (stages[i] - 1)) & 1;
        if ((s % (PERIOD / 2)) == 0) fb ^= 1;
        return ((s * 2) % PERIOD) + fb;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle, update the model, and compare after the edge.
    task automatic cycle(input bit ld, input int sd, input bit adv, input string req);
        seed_load = ld;
        seed_val  = N'(sd);
        adv_en    = adv;
        @(posedge clk);
        if (ld)       model = sd % PERIOD;
        else if (adv) model = model_next(model);
        #1;
        check(req, int'(state_q), model);
        check("R8", int'(ser_out), (model >> (N - 1)) & 1);
    endtask

    initial begin
        #(CLK_T * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit visited[PERIOD];
        int start;
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        model = 0;
        check("R1", int'(state_q), 0);
        rst = 1'b0;

        // R7 full period from reset, with R4 R5 R6 R9 checked every step.
        foreach (visited[i]) visited[i] = 1'b0;
        start = model;
        for (int i = 0; i < PERIOD; i++) begin
            total++;
            if (visited[int'(state_q)]) begin
                bad++;
                $display("FAIL R7 actual=repeat %0h expected=unvisited", state_q);
            end
            visited[int'(state_q)] = 1'b1;
            cycle(1'b0, 0, 1'b1, "R4 R9");
        end
        check("R7", int'(state_q), start);

        // R3 hold with enable low.
        for (int i = 0; i < 5; i++) cycle(1'b0, 0, 1'b0, "R3");

        // R2 load with and without advance in the same cycle.
        cycle(1'b1, 'hA5, 1'b1, "R2");
        cycle(1'b0, 0, 1'b1, "R4");
        cycle(1'b1, 'h3C, 1'b0, "R2");
        cycle(1'b0, 0, 1'b0, "R3");

        // R6 and R5 splice points.
        cycle(1'b1, 'h80, 1'b1, "R2");
        cycle(1'b0, 0, 1'b1, "R6");
        check("R6", int'(state_q), 0);
        cycle(1'b0, 0, 1'b1, "R5");
        check("R5", int'(state_q), 1);

        // Reset mid-sequence.
        for (int i = 0; i < 7; i++) cycle(1'b0, 0, 1'b1, "R4");
        rst = 1'b1;
        @(posedge clk); #1;
        model = 0;
        check("R1", int'(state_q), 0);
        rst = 1'b0;
        cycle(1'b0, 0, 1'b1, "R5");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule